// File: doc/BRIEF.md
# Jacobi Eigen Solver Sequencer

This block steers the two-sided Jacobi method for a small real symmetric matrix of order N (4 or 8). The matrix is held in 18-bit fixed point with 15 fractional bits. After a start pulse it takes the matrix word by word into a working store and sets a second store to the identity. Then it runs a fixed number of sweeps, with no convergence test. Each sweep has four steps. The block first asks an external arithmetic unit for one angle per 2x2 block on the diagonal. It then sends every row rotation and every column rotation of the working store to that unit, then the column rotations of the eigenvector store. Last, it moves to a new row/column pairing. When all sweeps are done it streams out the diagonal of the working store as eigenvalues, then the eigenvector store column by column.

The arithmetic stays outside the block and is reached through a single request/acknowledge channel, so the same sequencer can sit in front of any rotation engine. The pairing is applied by relabelling indices in a small order table. Stored data never moves.

Top module: `jeig_seq`

## Requirements
- R1: After reset, and whenever the block is idle, busy, done, out_valid and rot_req are all low.
- R2: A start pulse while idle begins a load. The next N*N cycles in which in_valid is high each store one in_data word, in row-major order. Cycles with in_valid low store nothing. The eigenvector store is set to the identity, where 1.0 is 0x08000.
- R3: A sweep first issues one angle request (rot_kind 0) per diagonal block i, for i = 0 up to N/2-1. Let p and q be order-table entries 2i and 2i+1. The request carries rot_a = S[p][p], rot_b = S[p][q] and rot_c = S[q][q]. The rot_x returned becomes angle i.
- R4: Next come rotation requests (rot_kind 1), with rot_a = x, rot_b = y and rot_c = angle i. For each block in turn, and for e from 0 up to N-1, the block sends all rows (S[p][e], S[q][e]), then all columns (S[e][p], S[e][q]), then eigenvector columns (V[e][p], V[e][q]). Each result pair (rot_x, rot_y) is written back in place of (x, y).
- R5: rot_req stays high, with rot_kind and the operands unchanged, until a cycle in which rot_ack is high. That cycle completes the request.
- R6: The order table starts as 0,1,...,N-1. After every sweep it is re-paired. Take the list of even entries and the list of odd entries. Even entry 0 stays in place. Odd entry 0 moves to even slot 1. Each later even entry moves up one even slot. Each odd entry moves down one odd slot. The last even entry moves to the last odd slot.
- R7: Exactly SWEEPS sweeps run, which gives SWEEPS*N/2 angle requests and SWEEPS*3*(N/2)*N rotation requests.
- R8: The block then outputs, one word per cycle with out_valid high, S[k][k] for k from 0 to N-1, followed by V in column-major order.
- R9: done is high for exactly one cycle, the cycle after the last output word. busy is low from the cycle after that.
- R10: A start pulse while busy has no effect on the run in progress and does not begin a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a solve when idle |
| busy | output | 1 | A solve is in progress |
| done | output | 1 | One-cycle end-of-solve pulse |
| in_valid | input | 1 | in_data carries a matrix word |
| in_data | input | 18 | Matrix word, row-major |
| rot_req | output | 1 | Arithmetic request pending |
| rot_kind | output | 1 | 0 angle, 1 rotation |
| rot_a | output | 18 | Operand a (S[p][p] or x) |
| rot_b | output | 18 | Operand b (S[p][q] or y) |
| rot_c | output | 18 | Operand c (S[q][q] or angle) |
| rot_ack | input | 1 | Result valid, completes the request |
| rot_x | input | 18 | Angle, or rotated x |
| rot_y | input | 18 | Rotated y |
| out_valid | output | 1 | out_data carries a result word |
| out_data | output | 18 | Eigenvalue or eigenvector word |

## Verification
The hardest thing to observe is the re-pairing. The order table never shows at the ports, and its effect only builds up over several sweeps in the final words. To reach it, the bench stands in for the arithmetic unit with simple fixed operations that depend on operand order. Every pairing mistake, ordering slip or missed write-back then changes the values that come out. The same responder stretches its acknowledge over several cycles so that the request hold is exercised, and it checks the operands of the very first angle request against the loaded matrix.

// File: rtl/jeig_pkg.sv
package jeig_pkg;
  localparam int WL   = 18;
  localparam int FRAC = 15;
  typedef logic [WL-1:0] word_t;
  localparam word_t UNITY = word_t'(1 << FRAC);

  typedef enum logic [3:0] {
    ST_IDLE, ST_LOAD, ST_ANG, ST_ROWR, ST_COLR, ST_VROT,
    ST_PERM, ST_OUTD, ST_OUTV, ST_FIN
  } jeig_state_e;
endpackage

// File: rtl/jeig_order.sv
module jeig_order #(
  parameter int N = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          init,
  input  logic                          step,
  output logic [N-1:0][$clog2(N)-1:0]   ord
);
  localparam int M  = N / 2;
  localparam int LW = $clog2(N);

  logic [N-1:0][LW-1:0] cur_q, nxt;
  logic [N-1:0]         seen;

  // round-robin re-pairing: even slot 0 fixed, evens shift up, odds shift down
  always_comb begin
    for (int j = 0; j < M; j++) begin
      if (j == 0)      nxt[0]     = cur_q[0];
      else if (j == 1) nxt[2]     = cur_q[1];
      else             nxt[2*j]   = cur_q[2*(j-1)];
      if (j == M-1)    nxt[2*j+1] = cur_q[2*j];
      else             nxt[2*j+1] = cur_q[2*(j+1)+1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) cur_q[k] <= LW'(k);
    end else if (init) begin
      for (int k = 0; k < N; k++) cur_q[k] <= LW'(k);
    end else if (step) begin
      cur_q <= nxt;
    end
  end

  assign ord = cur_q;

  always_comb begin
    seen = '0;
    for (int k = 0; k < N; k++) seen[cur_q[k]] = 1'b1;
  end

  // R6: table always holds every index exactly once
  p_order_perm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(seen) == N);
endmodule

// File: rtl/jeig_store.sv
module jeig_store
  import jeig_pkg::*;
#(
  parameter int N     = 8,
  parameter int RP    = 2,
  parameter bit IDENT = 1'b0
) (
  input  logic                              clk,
  input  logic                              init,
  input  logic                              we0,
  input  logic [2*$clog2(N)-1:0]            wa0,
  input  word_t                             wd0,
  input  logic                              we1,
  input  logic [2*$clog2(N)-1:0]            wa1,
  input  word_t                             wd1,
  input  logic [RP-1:0][2*$clog2(N)-1:0]    ra,
  output logic [RP-1:0][WL-1:0]             rd
);
  localparam int DEPTH = N * N;

  word_t mem [DEPTH];

  generate
    if (IDENT) begin : g_ident
      always_ff @(posedge clk) begin
        if (init) begin
          for (int k = 0; k < DEPTH; k++)
            mem[k] <= ((k / N) == (k % N)) ? UNITY : '0;
        end else begin
          if (we0) mem[wa0] <= wd0;
          if (we1) mem[wa1] <= wd1;
        end
      end
    end else begin : g_zero
      always_ff @(posedge clk) begin
        if (init) begin
          for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
        end else begin
          if (we0) mem[wa0] <= wd0;
          if (we1) mem[wa1] <= wd1;
        end
      end
    end
  endgenerate

  for (genvar r = 0; r < RP; r++) begin : g_rd
    assign rd[r] = mem[ra[r]];
  end
endmodule

// File: rtl/jeig_seq.sv
module jeig_seq
  import jeig_pkg::*;
#(
  parameter int N      = 8,
  parameter int SWEEPS = 26
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        busy,
  output logic        done,
  input  logic        in_valid,
  input  logic [17:0] in_data,
  output logic        rot_req,
  output logic        rot_kind,
  output logic [17:0] rot_a,
  output logic [17:0] rot_b,
  output logic [17:0] rot_c,
  input  logic        rot_ack,
  input  logic [17:0] rot_x,
  input  logic [17:0] rot_y,
  output logic        out_valid,
  output logic [17:0] out_data
);
  localparam int M   = N / 2;
  localparam int LW  = $clog2(N);
  localparam int MW  = LW - 1;
  localparam int AW  = 2 * LW;
  localparam int SWW = $clog2(SWEEPS + 1);
  localparam logic [LW-1:0]  IDX_LAST = LW'(N - 1);
  localparam logic [LW-1:0]  BLK_LAST = LW'(M - 1);
  localparam logic [AW-1:0]  LD_LAST  = AW'(N * N - 1);
  localparam logic [SWW-1:0] SW_LAST  = SWW'(SWEEPS - 1);

  jeig_state_e     state_q, state_d;
  logic [LW-1:0]   e_q, e_d, i_q, i_d;
  logic [SWW-1:0]  sw_q, sw_d;
  logic [AW-1:0]   ld_q, ld_d;
  word_t           ang_q [M];
  logic            ang_we, ord_init, ord_step, st_init;

  logic [N-1:0][LW-1:0] ord;
  logic [MW-1:0]        blk;
  logic [LW-1:0]        p_idx, q_idx;

  logic [2:0][AW-1:0]   s_ra;
  logic [2:0][WL-1:0]   s_rd;
  logic [1:0][AW-1:0]   v_ra;
  logic [1:0][WL-1:0]   v_rd;
  logic                 s_we0, s_we1, v_we;
  logic [AW-1:0]        s_wa0;
  word_t                s_wd0;

  assign blk   = i_q[MW-1:0];
  assign p_idx = ord[{blk, 1'b0}];
  assign q_idx = ord[{blk, 1'b1}];

  jeig_order #(.N(N)) u_order (
    .clk(clk), .rst_n(rst_n), .init(ord_init), .step(ord_step), .ord(ord)
  );

  jeig_store #(.N(N), .RP(3), .IDENT(1'b0)) u_sstore (
    .clk(clk), .init(st_init),
    .we0(s_we0), .wa0(s_wa0), .wd0(s_wd0),
    .we1(s_we1), .wa1(s_ra[1]), .wd1(rot_y),
    .ra(s_ra), .rd(s_rd)
  );

  jeig_store #(.N(N), .RP(2), .IDENT(1'b1)) u_vstore (
    .clk(clk), .init(st_init),
    .we0(v_we), .wa0(v_ra[0]), .wd0(rot_x),
    .we1(v_we), .wa1(v_ra[1]), .wd1(rot_y),
    .ra(v_ra), .rd(v_rd)
  );

  // next-state and counters
  always_comb begin
    state_d  = state_q;
    e_d      = e_q;
    i_d      = i_q;
    sw_d     = sw_q;
    ld_d     = ld_q;
    ang_we   = 1'b0;
    ord_init = 1'b0;
    ord_step = 1'b0;
    st_init  = 1'b0;
    case (state_q)
      ST_IDLE: if (start) begin
        state_d  = ST_LOAD;
        ld_d     = '0;
        e_d      = '0;
        i_d      = '0;
        sw_d     = '0;
        ord_init = 1'b1;
        st_init  = 1'b1;
      end
      ST_LOAD: if (in_valid) begin
        ld_d = ld_q + 1'b1;
        if (ld_q == LD_LAST) state_d = ST_ANG;
      end
      ST_ANG: if (rot_ack) begin
        ang_we = 1'b1;
        if (i_q == BLK_LAST) begin
          i_d     = '0;
          state_d = ST_ROWR;
        end else i_d = i_q + 1'b1;
      end
      ST_ROWR, ST_COLR, ST_VROT: if (rot_ack) begin
        if (e_q == IDX_LAST) begin
          e_d = '0;
          if (i_q == BLK_LAST) begin
            i_d     = '0;
            state_d = (state_q == ST_ROWR) ? ST_COLR :
                      (state_q == ST_COLR) ? ST_VROT : ST_PERM;
          end else i_d = i_q + 1'b1;
        end else e_d = e_q + 1'b1;
      end
      ST_PERM: begin
        ord_step = 1'b1;
        if (sw_q == SW_LAST) begin
          sw_d    = '0;
          state_d = ST_OUTD;
        end else begin
          sw_d    = sw_q + 1'b1;
          state_d = ST_ANG;
        end
      end
      ST_OUTD: if (e_q == IDX_LAST) begin
        e_d     = '0;
        state_d = ST_OUTV;
      end else e_d = e_q + 1'b1;
      ST_OUTV: if (e_q == IDX_LAST) begin
        e_d = '0;
        if (i_q == IDX_LAST) begin
          i_d     = '0;
          state_d = ST_FIN;
        end else i_d = i_q + 1'b1;
      end else e_d = e_q + 1'b1;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // operand routing, write-back and output select
  always_comb begin
    s_ra      = '0;
    v_ra      = '0;
    s_we0     = 1'b0;
    s_we1     = 1'b0;
    s_wa0     = s_ra[0];
    s_wd0     = rot_x;
    v_we      = 1'b0;
    rot_req   = 1'b0;
    rot_kind  = 1'b0;
    rot_a     = '0;
    rot_b     = '0;
    rot_c     = '0;
    out_valid = 1'b0;
    out_data  = '0;
    case (state_q)
      ST_LOAD: begin
        s_we0 = in_valid;
        s_wa0 = ld_q;
        s_wd0 = in_data;
      end
      ST_ANG: begin
        s_ra    = {{p_idx, p_idx}, {q_idx, q_idx}, {p_idx, q_idx}, {p_idx, p_idx}} >> AW;
        s_ra[0] = {p_idx, p_idx};
        s_ra[1] = {p_idx, q_idx};
        s_ra[2] = {q_idx, q_idx};
        rot_req = 1'b1;
        rot_a   = s_rd[0];
        rot_b   = s_rd[1];
        rot_c   = s_rd[2];
      end
      ST_ROWR, ST_COLR: begin
        s_ra[0]  = (state_q == ST_ROWR) ? {p_idx, e_q} : {e_q, p_idx};
        s_ra[1]  = (state_q == ST_ROWR) ? {q_idx, e_q} : {e_q, q_idx};
        s_wa0    = s_ra[0];
        s_we0    = rot_ack;
        s_we1    = rot_ack;
        rot_req  = 1'b1;
        rot_kind = 1'b1;
        rot_a    = s_rd[0];
        rot_b    = s_rd[1];
        rot_c    = ang_q[blk];
      end
      ST_VROT: begin
        v_ra[0]  = {e_q, p_idx};
        v_ra[1]  = {e_q, q_idx};
        v_we     = rot_ack;
        rot_req  = 1'b1;
        rot_kind = 1'b1;
        rot_a    = v_rd[0];
        rot_b    = v_rd[1];
        rot_c    = ang_q[blk];
      end
      ST_OUTD: begin
        s_ra[0]   = {e_q, e_q};
        out_valid = 1'b1;
        out_data  = s_rd[0];
      end
      ST_OUTV: begin
        v_ra[0]   = {e_q, i_q};
        out_valid = 1'b1;
        out_data  = v_rd[0];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      e_q     <= '0;
      i_q     <= '0;
      sw_q    <= '0;
      ld_q    <= '0;
    end else begin
      state_q <= state_d;
      e_q     <= e_d;
      i_q     <= i_d;
      sw_q    <= sw_d;
      ld_q    <= ld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < M; k++) ang_q[k] <= '0;
    end else if (ang_we) begin
      ang_q[blk] <= rot_x;
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign done = (state_q == ST_FIN);

  // R5: a pending request holds its operands until acknowledged
  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rot_req && !rot_ack |=> rot_req && $stable({rot_kind, rot_a, rot_b, rot_c}));
  // R5: acknowledge only answers a pending request
  p_ack_in_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rot_ack |-> rot_req);
  // R1: idle means no request and no output
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rot_req && !out_valid && !done);
  // R8: output words only during a solve
  p_out_in_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy && !rot_req);
  // R9: done is a single-cycle pulse followed by idle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
  // R10: start during a run does not end or restart it
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done && start |=> busy);
endmodule

// File: tb/jeig_seq_bench.sv
module jeig_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int M  = N / 2;
  localparam int SW = 3;
  localparam int NW = N + N * N;

  logic clk = 1'b0;
  logic rst_n;
  logic start, in_valid;
  logic [17:0] in_data;
  logic busy, done, rot_req, rot_kind, out_valid;
  logic [17:0] rot_a, rot_b, rot_c, out_data;
  logic rot_ack;
  logic [17:0] rot_x, rot_y;

  int n_checks = 0;
  int n_fail   = 0;
  int lat      = 0;
  int n_ang, n_rot;
  bit seen_first;

  logic signed [17:0] mat [N*N];
  logic signed [17:0] ms  [N*N];
  logic signed [17:0] mv  [N*N];
  logic signed [17:0] mang [M];
  logic signed [17:0] exp_out [NW];
  int ml [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  jeig_seq #(.N(N), .SWEEPS(SW)) u_jeig_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .in_valid(in_valid), .in_data(in_data),
    .rot_req(rot_req), .rot_kind(rot_kind), .rot_a(rot_a), .rot_b(rot_b),
    .rot_c(rot_c), .rot_ack(rot_ack), .rot_x(rot_x), .rot_y(rot_y),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic signed [17:0] f_ang(input logic signed [17:0] a, b, c);
    return a + (b <<< 1) - c;
  endfunction
  function automatic logic signed [17:0] f_rx(input logic signed [17:0] x, y, c);
    return x - (y >>> 1) + c;
  endfunction
  function automatic logic signed [17:0] f_ry(input logic signed [17:0] x, y, c);
    return y + (x >>> 2) - c;
  endfunction

  task automatic check(input bit ok, input string req, input logic [17:0] act, input logic [17:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
    end
  endtask

  // reference model built from the requirement text
  task automatic compute_expected();
    int p, q;
    int tp [M];
    int bt [M];
    logic signed [17:0] x, y;
    for (int k = 0; k < N*N; k++) begin
      ms[k] = mat[k];
      mv[k] = ((k / N) == (k % N)) ? 18'sh08000 : 18'sh0;
    end
    for (int k = 0; k < N; k++) ml[k] = k;
    for (int s = 0; s < SW; s++) begin
      for (int i = 0; i < M; i++) begin
        p = ml[2*i]; q = ml[2*i+1];
        mang[i] = f_ang(ms[p*N+p], ms[p*N+q], ms[q*N+q]);
      end
      for (int i = 0; i < M; i++) begin
        p = ml[2*i]; q = ml[2*i+1];
        for (int e = 0; e < N; e++) begin
          x = ms[p*N+e]; y = ms[q*N+e];
          ms[p*N+e] = f_rx(x, y, mang[i]); ms[q*N+e] = f_ry(x, y, mang[i]);
        end
      end
      for (int i = 0; i < M; i++) begin
        p = ml[2*i]; q = ml[2*i+1];
        for (int e = 0; e < N; e++) begin
          x = ms[e*N+p]; y = ms[e*N+q];
          ms[e*N+p] = f_rx(x, y, mang[i]); ms[e*N+q] = f_ry(x, y, mang[i]);
        end
      end
      for (int i = 0; i < M; i++) begin
        p = ml[2*i]; q = ml[2*i+1];
        for (int e = 0; e < N; e++) begin
          x = mv[e*N+p]; y = mv[e*N+q];
          mv[e*N+p] = f_rx(x, y, mang[i]); mv[e*N+q] = f_ry(x, y, mang[i]);
        end
      end
      for (int j = 0; j < M; j++) begin tp[j] = ml[2*j]; bt[j] = ml[2*j+1]; end
      ml[0] = tp[0];
      ml[2] = bt[0];
      for (int j = 2; j < M; j++) ml[2*j] = tp[j-1];
      for (int j = 0; j < M-1; j++) ml[2*j+1] = bt[j+1];
      ml[2*M-1] = tp[M-1];
    end
    for (int k = 0; k < N; k++) exp_out[k] = ms[k*N+k];
    for (int c = 0; c < N; c++)
      for (int r = 0; r < N; r++) exp_out[N + c*N + r] = mv[r*N+c];
  endtask

  // stand-in arithmetic unit
  initial begin
    logic k0;
    logic [17:0] a0, b0, c0;
    rot_ack = 1'b0; rot_x = '0; rot_y = '0;
    forever begin
      @(negedge clk);
      if (rot_ack) rot_ack = 1'b0;
      else if (rot_req) begin
        k0 = rot_kind; a0 = rot_a; b0 = rot_b; c0 = rot_c;
        if (!k0) begin
          n_ang++;
          if (!seen_first) begin
            seen_first = 1'b1;
            check(a0 == mat[0],   "R3 first angle a", a0, mat[0]);
            check(b0 == mat[1],   "R3 first angle b", b0, mat[1]);
            check(c0 == mat[N+1], "R3 first angle c", c0, mat[N+1]);
          end
        end else n_rot++;
        for (int w = 0; w < lat; w++) begin
          @(negedge clk);
          check(rot_req && rot_kind == k0 && rot_a == a0 && rot_b == b0 && rot_c == c0,
                "R5 request hold", rot_a, a0);
        end
        if (!k0) begin rot_x = f_ang(a0, b0, c0); rot_y = '0; end
        else begin rot_x = f_rx(a0, b0, c0); rot_y = f_ry(a0, b0, c0); end
        rot_ack = 1'b1;
      end
    end
  end

  task automatic t_reset_state();
    check(!busy,      "R1 busy after reset",      busy,      0);
    check(!done,      "R1 done after reset",      done,      0);
    check(!out_valid, "R1 out_valid after reset", out_valid, 0);
    check(!rot_req,   "R1 rot_req after reset",   rot_req,   0);
  endtask

  task automatic run_solve(input int latency, input bit gaps, input bit poke);
    int got;
    lat = latency; n_ang = 0; n_rot = 0; seen_first = 1'b0;
    compute_expected();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < N*N; k++) begin
      if (gaps && (k % 3 == 1)) begin in_valid = 1'b0; @(negedge clk); end
      in_valid = 1'b1; in_data = mat[k];
      @(negedge clk);
    end
    in_valid = 1'b0; in_data = '0;
    if (poke) begin
      repeat (5) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
      check(busy, "R10 start while busy", busy, 1);
    end
    got = 0;
    while (got < NW) begin
      @(negedge clk);
      if (out_valid) begin
        check(out_data == exp_out[got],
              (got < N) ? "R8 R7 eigenvalue word" : "R2 R4 R6 eigenvector word",
              out_data, exp_out[got]);
        got++;
      end
    end
    @(negedge clk);
    check(done && !out_valid, "R9 done after last word", done, 1);
    @(negedge clk);
    check(!done && !busy, "R9 single done then idle", {done, busy}, 0);
    repeat (3) @(negedge clk);
    check(!busy, "R10 no queued restart", busy, 0);
    check(n_ang == SW*M,       "R7 angle request count",    n_ang, SW*M);
    check(n_rot == SW*3*M*N,   "R4 rotation request count", n_rot, SW*3*M*N);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R9 actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; in_valid = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    // case 1: immediate responder, dense load
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++)
        mat[r*N+c] = 18'((r + c) * 3000 - 4000 + ((r == c) ? 9000 : 0));
    run_solve(0, 1'b0, 1'b0);
    // case 2: slow responder, gapped load, start poked mid-run
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++)
        mat[r*N+c] = 18'((r*r + c*c) * 1500 - 7000);
    run_solve(3, 1'b1, 1'b1);
    // case 3: one-cycle latency, negative-heavy matrix
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++)
        mat[r*N+c] = 18'(-(r + 1) * (c + 1) * 1200 + 500);
    run_solve(1, 1'b1, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule